// File: doc/BRIEF.md
# Six-Channel Multi-Mode 16-bit Timer Group

This block holds six independent 16-bit up-counting timer channels. Each channel runs in one of four modes. In auto-reload mode it is a periodic timer. In compare mode it toggles its output pin when the count matches a set value. In PWM mode it drives a pulse-width modulated waveform. In capture mode it latches the current count when its input pin changes.

Each channel counts on a count-enable strobe that it picks from eight sources. Seven sources are clock-enable strobes supplied from outside the block. The eighth is an external clock pin, and only channels 0 and 1 have one. A write port loads each channel's mode, clock source, reload value and compare value. A shared group control starts or stops any set of channels in the same clock cycle. Each channel has a capture input pin, an output pin and a one-cycle interrupt request.

Top module: `tmr_group`

## Requirements
- R1: After a synchronous reset, every channel is stopped, and every count, capture register, output pin and interrupt request is zero.
- R2: A `grp_start` bit starts its channel and loads the count from the reload register in the same cycle. Any number of channels can be started together. A `grp_stop` bit halts its channel, and the count is held. If start and stop are both set for one channel, stop wins.
- R3: A running channel adds one to its count on every clock edge at which its selected strobe is high. Clock-select values 0 to 6 choose `pre_ce[0]` to `pre_ce[6]`, and value 7 chooses the external clock.
- R4: In auto-reload mode (mode 0), a tick at count 0xFFFF loads the reload value and pulses `irq` for exactly one cycle.
- R5: In compare mode (mode 1), a tick taken while the count equals the compare value toggles the output and pulses `irq`. The output starts low at channel start and is low while the channel is stopped.
- R6: In PWM mode (mode 2), the output is high while the channel runs and the count is below the compare value, and low otherwise. `irq` pulses on each overflow.
- R7: Values written to reload and compare while a channel runs take effect only at the next overflow or the next start. The current period keeps the old values.
- R8: In capture mode (mode 3), the selected edge of `cap_in` latches the count into the capture register and pulses `irq`. Config bit 5 selects the edge: 0 for rising, 1 for falling. The opposite edge has no effect. The pin is synchronised through two flops, so the new capture value appears 3 clock edges after the pin changes. The pin must stay at each level for at least 2 cycles.
- R9: With clock-select value 7, channels 0 and 1 count the rising edges of `ext_clk[0]` and `ext_clk[1]`, after the same two-flop synchroniser. Each high and each low phase must last at least 2 cycles. A channel without an external pin never counts with clock-select value 7.
- R10: Write-port fields are selected by `wr_sel`:
  - 0 writes the config word: bits [1:0] are the mode, bits [4:2] the clock select, bit 5 the capture edge.
  - 1 writes the reload value.
  - 2 writes the compare value.
  - 3 is ignored.
  `rd_cnt` and `rd_cap` show the channel chosen by `rd_ch` without delay, and read as zero for channel numbers above 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 3 | Channel addressed by the write |
| wr_sel | input | 2 | Field select: config, reload, compare, none |
| wr_data | input | 16 | Write data |
| grp_start | input | 6 | Start mask, one bit per channel |
| grp_stop | input | 6 | Stop mask, one bit per channel |
| pre_ce | input | 7 | Clock-enable strobes for clock-select values 0 to 6 |
| ext_clk | input | 2 | External clock pins for channels 0 and 1 |
| cap_in | input | 6 | Capture input pins |
| rd_ch | input | 3 | Channel shown on the read outputs |
| rd_cnt | output | 16 | Count of the selected channel |
| rd_cap | output | 16 | Capture register of the selected channel |
| tmr_out | output | 6 | Compare and PWM output pins |
| irq | output | 6 | One-cycle interrupt requests |
| run_o | output | 6 | Channel running flags |

## Verification
The count, the `irq` pulse and the compare toggle are registered, so each is due one edge after the qualifying strobe. The PWM output follows the count without delay. Capture results and external-clock ticks arrive three edges after a pin change, because of the synchroniser. The bench drives every input on the falling edge and reads results on a later falling edge. It counts interrupt pulses on rising edges, so each pulse is counted exactly once. Before reading results, it waits at least one full cycle past the last register stage, or four cycles after any pin change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 16;
    localparam int NSRC   = 8;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int CFG_W  = 6;

    typedef enum logic [1:0] {
        M_RELOAD = 2'd0,
        M_CMP    = 2'd1,
        M_PWM    = 2'd2,
        M_CAP    = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        F_CFG  = 2'd0,
        F_RLD  = 2'd1,
        F_CMP  = 2'd2,
        F_NONE = 2'd3
    } tmr_field_e;

    typedef struct packed {
        logic             edge_fall;
        logic [SRC_W-1:0] cks;
        tmr_mode_e        mode;
    } tmr_cfg_t;

    function automatic tmr_cfg_t cfg_from_word(input logic [CNT_W-1:0] w);
        return tmr_cfg_t'(w[CFG_W-1:0]);
    endfunction

    function automatic logic irq_on_wrap(input tmr_mode_e m);
        return (m == M_RELOAD) || (m == M_PWM);
    endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_d
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= '0;
            lvl   <= '0;
            lvl_d <= '0;
        end else begin
            s1    <= din;
            lvl   <= s1;
            lvl_d <= lvl;
        end
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  tmr_field_e       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             start,
    input  logic             stop,
    input  logic [NSRC-1:0]  ce_vec,
    input  logic             cap_rise,
    input  logic             cap_fall,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             out_o,
    output logic             irq_o,
    output logic             run_o
);
    tmr_cfg_t         cfg;
    logic [CNT_W-1:0] cnt, rld_sh, cmp_sh, cmp_act, cap_q;
    logic             run, tog, irq_q;

    logic tick, wrap, at_cmp, cap_hit;

    always_comb begin
        tick    = run && ce_vec[cfg.cks];
        wrap    = (cnt == {CNT_W{1'b1}});
        at_cmp  = (cnt == cmp_act);
        cap_hit = (cfg.mode == M_CAP) && (cfg.edge_fall ? cap_fall : cap_rise);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            cnt     <= '0;
            rld_sh  <= '0;
            cmp_sh  <= '0;
            cmp_act <= '0;
            cap_q   <= '0;
            run     <= 1'b0;
            tog     <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_en) begin
                case (wr_sel)
                    F_CFG:   cfg    <= cfg_from_word(wr_data);
                    F_RLD:   rld_sh <= wr_data;
                    F_CMP:   cmp_sh <= wr_data;
                    default: ;
                endcase
            end
            if (stop) begin
                run <= 1'b0;
            end else if (start) begin
                run     <= 1'b1;
                cnt     <= rld_sh;
                cmp_act <= cmp_sh;
                tog     <= 1'b0;
            end else if (run) begin
                if (tick) begin
                    if (wrap) begin
                        cnt     <= rld_sh;
                        cmp_act <= cmp_sh;
                        if (irq_on_wrap(cfg.mode)) irq_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    if ((cfg.mode == M_CMP) && at_cmp) begin
                        tog   <= ~tog;
                        irq_q <= 1'b1;
                    end
                end
                if (cap_hit) begin
                    cap_q <= cnt;
                    irq_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (cfg.mode)
            M_PWM:   out_o = run && (cnt < cmp_act);
            M_CMP:   out_o = run && tog;
            default: out_o = 1'b0;
        endcase
    end

    assign cnt_o = cnt;
    assign cap_o = cap_q;
    assign irq_o = irq_q;
    assign run_o = run;
endmodule

// File: rtl/tmr_group.sv
module tmr_group
    import tmr_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int NEXT = 2,
    parameter int CW   = CNT_W,
    localparam int CHW = $clog2(NCH),
    localparam int NPRE = NSRC - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [CHW-1:0]  wr_ch,
    input  logic [1:0]      wr_sel,
    input  logic [CW-1:0]   wr_data,
    input  logic [NCH-1:0]  grp_start,
    input  logic [NCH-1:0]  grp_stop,
    input  logic [NPRE-1:0] pre_ce,
    input  logic [NEXT-1:0] ext_clk,
    input  logic [NCH-1:0]  cap_in,
    input  logic [CHW-1:0]  rd_ch,
    output logic [CW-1:0]   rd_cnt,
    output logic [CW-1:0]   rd_cap,
    output logic [NCH-1:0]  tmr_out,
    output logic [NCH-1:0]  irq,
    output logic [NCH-1:0]  run_o
);
    logic [NCH-1:0]           cap_lvl, cap_lvl_d, cap_rise, cap_fall;
    logic [NEXT-1:0]          ext_lvl, ext_lvl_d, ext_rise;
    logic [NCH-1:0][CW-1:0]   cnt_all;
    logic [NCH-1:0][CW-1:0]   cap_all;
    tmr_field_e               field;

    assign field = tmr_field_e'(wr_sel);

    tmr_sync #(.W(NCH)) u_cap_sync (
        .clk(clk), .rst(rst), .din(cap_in), .lvl(cap_lvl), .lvl_d(cap_lvl_d)
    );
    tmr_sync #(.W(NEXT)) u_ext_sync (
        .clk(clk), .rst(rst), .din(ext_clk), .lvl(ext_lvl), .lvl_d(ext_lvl_d)
    );

    assign cap_rise = cap_lvl & ~cap_lvl_d;
    assign cap_fall = ~cap_lvl & cap_lvl_d;
    assign ext_rise = ext_lvl & ~ext_lvl_d;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [NSRC-1:0] ce_vec;
        if (i < NEXT) begin : g_ext
            assign ce_vec = {ext_rise[i], pre_ce};
        end else begin : g_noext
            assign ce_vec = {1'b0, pre_ce};
        end

        tmr_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (wr_ch == CHW'(i))),
            .wr_sel   (field),
            .wr_data  (wr_data),
            .start    (grp_start[i]),
            .stop     (grp_stop[i]),
            .ce_vec   (ce_vec),
            .cap_rise (cap_rise[i]),
            .cap_fall (cap_fall[i]),
            .cnt_o    (cnt_all[i]),
            .cap_o    (cap_all[i]),
            .out_o    (tmr_out[i]),
            .irq_o    (irq[i]),
            .run_o    (run_o[i])
        );
    end

    always_comb begin
        rd_cnt = '0;
        rd_cap = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CHW'(i)) begin
                rd_cnt = cnt_all[i];
                rd_cap = cap_all[i];
            end
        end
    end
endmodule

// File: rtl/tmr_group_chk.sv
module tmr_group_chk #(
    parameter int NCH = 6,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCH-1:0]         grp_start,
    input logic [NCH-1:0]         grp_stop,
    input logic [NCH-1:0]         run_o,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0][CW-1:0] cnt_all
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_start_runs_r2: assert property (@(posedge clk) disable iff (rst)
            (grp_start[i] && !grp_stop[i]) |=> run_o[i]);

        p_stop_halts_r2: assert property (@(posedge clk) disable iff (rst)
            grp_stop[i] |=> !run_o[i]);

        p_stopped_hold_r2: assert property (@(posedge clk) disable iff (rst)
            (!run_o[i] && !grp_start[i]) |=> $stable(cnt_all[i]));

        p_irq_while_run_r4: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> $past(run_o[i]));

        p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
            (run_o[i] && $past(run_o[i]) && !$past(grp_start[i]) && !$stable(cnt_all[i]))
            |-> ((cnt_all[i] == $past(cnt_all[i]) + 1'b1) ||
                 ($past(cnt_all[i]) == {CW{1'b1}})));
    end
endmodule

bind tmr_group tmr_group_chk #(.NCH(NCH), .CW(CW)) u_chk (.*);

// File: tb/sim_tmr_group.sv
module sim_tmr_group;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_ch = '0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  grp_start = '0;
    logic [5:0]  grp_stop = '0;
    logic [6:0]  pre_ce = '0;
    logic [1:0]  ext_clk = '0;
    logic [5:0]  cap_in = '0;
    logic [2:0]  rd_ch = '0;
    logic [15:0] rd_cnt, rd_cap;
    logic [5:0]  tmr_out, irq, run_o;

    int n_chk = 0;
    int n_bad = 0;
    int irq_seen = 0;
    int mon_ch = 0;

    always #5 clk = ~clk;

    tmr_group u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .grp_start(grp_start), .grp_stop(grp_stop),
        .pre_ce(pre_ce), .ext_clk(ext_clk), .cap_in(cap_in), .rd_ch(rd_ch),
        .rd_cnt(rd_cnt), .rd_cap(rd_cap), .tmr_out(tmr_out), .irq(irq),
        .run_o(run_o)
    );

    always @(posedge clk) if (!rst && irq[mon_ch]) irq_seen++;

    typedef struct packed {
        logic [2:0]  ch;
        logic [1:0]  mode;
        logic [15:0] rld;
        logic [15:0] cmp;
        logic [7:0]  n;
        logic [15:0] ecnt;
        logic        eout;
        logic [3:0]  eirq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{3'd0, 2'd0, 16'hFFF0, 16'h0000, 8'd5,  16'hFFF5, 1'b0, 4'd0},
        '{3'd1, 2'd0, 16'hFFF0, 16'h0000, 8'd16, 16'hFFF0, 1'b0, 4'd1},
        '{3'd2, 2'd0, 16'hFFF0, 16'h0000, 8'd37, 16'hFFF5, 1'b0, 4'd2},
        '{3'd3, 2'd1, 16'hFFF0, 16'hFFF4, 8'd5,  16'hFFF5, 1'b1, 4'd1},
        '{3'd4, 2'd1, 16'hFFF0, 16'hFFF4, 8'd21, 16'hFFF5, 1'b0, 4'd2},
        '{3'd5, 2'd2, 16'hFFF0, 16'hFFF8, 8'd3,  16'hFFF3, 1'b1, 4'd0},
        '{3'd0, 2'd2, 16'hFFF0, 16'hFFF8, 8'd10, 16'hFFFA, 1'b0, 4'd0},
        '{3'd1, 2'd2, 16'hFFF0, 16'hFFF8, 8'd17, 16'hFFF1, 1'b1, 4'd1},
        '{3'd2, 2'd2, 16'hFFF0, 16'hFFF0, 8'd2,  16'hFFF2, 1'b0, 4'd0},
        '{3'd3, 2'd0, 16'hFFFF, 16'h0000, 8'd3,  16'hFFFF, 1'b0, 4'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 3'(ch); wr_sel = 2'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic go(input logic [5:0] st, input logic [5:0] sp);
        @(negedge clk);
        grp_start = st; grp_stop = sp;
        @(negedge clk);
        grp_start = '0; grp_stop = '0;
    endtask

    task automatic ticks(input int bitn, input int n);
        @(negedge clk);
        pre_ce = 7'(1 << bitn);
        repeat (n) @(negedge clk);
        pre_ce = '0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 run", 32'(run_o), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 out", 32'(tmr_out), 0);
        for (int c = 0; c < 6; c++) begin
            rd_ch = 3'(c);
            #1;
            chk("R1 cnt", 32'(rd_cnt), 0);
            chk("R1 cap", 32'(rd_cap), 0);
        end

        // Vector table: R4 auto-reload, R5 compare, R6 PWM
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = (VT[v].mode == 2'd0) ? "R4" : (VT[v].mode == 2'd1) ? "R5" : "R6";
            wr(VT[v].ch, 0, 16'(VT[v].mode));
            wr(VT[v].ch, 1, VT[v].rld);
            wr(VT[v].ch, 2, VT[v].cmp);
            mon_ch = int'(VT[v].ch);
            rd_ch = VT[v].ch;
            @(negedge clk);
            irq_seen = 0;
            go(6'(1 << VT[v].ch), 6'd0);
            ticks(0, int'(VT[v].n));
            settle();
            chk({tag, " cnt"}, 32'(rd_cnt), 32'(VT[v].ecnt));
            chk({tag, " out"}, 32'(tmr_out[VT[v].ch]), 32'(VT[v].eout));
            chk({tag, " irq"}, 32'(irq_seen), 32'(VT[v].eirq));
            go(6'd0, 6'(1 << VT[v].ch));
            chk({tag, " stop out"}, 32'(tmr_out[VT[v].ch]), 0);
        end

        // R2 group start/stop
        wr(1, 0, 16'h0000); wr(1, 1, 16'h0000);
        wr(4, 0, 16'h0000); wr(4, 1, 16'h0000);
        go(6'b010010, 6'd0);
        chk("R2 run both", 32'(run_o), 32'h12);
        ticks(0, 4);
        rd_ch = 3'd1; #1; chk("R2 ch1 cnt", 32'(rd_cnt), 4);
        rd_ch = 3'd4; #1; chk("R2 ch4 cnt", 32'(rd_cnt), 4);
        go(6'd0, 6'b000010);
        ticks(0, 3);
        rd_ch = 3'd1; #1; chk("R2 ch1 held", 32'(rd_cnt), 4);
        rd_ch = 3'd4; #1; chk("R2 ch4 cnt", 32'(rd_cnt), 7);
        go(6'b000010, 6'b000010);
        chk("R2 stop wins", 32'(run_o[1]), 0);
        rd_ch = 3'd1; #1; chk("R2 stop wins cnt", 32'(rd_cnt), 4);
        go(6'd0, 6'b111111);

        // R3 clock select 4 only
        wr(5, 0, 16'h0010); wr(5, 1, 16'h0100);
        go(6'b100000, 6'd0);
        ticks(4, 3);
        ticks(0, 2); ticks(1, 2); ticks(3, 1); ticks(6, 2);
        rd_ch = 3'd5; #1; chk("R3 sel4", 32'(rd_cnt), 32'h0103);
        go(6'd0, 6'b100000);

        // R10 field 3 ignored; start reloads old reload value
        wr(5, 3, 16'hABCD);
        go(6'b100000, 6'd0);
        rd_ch = 3'd5; #1; chk("R10 sel3 ignored", 32'(rd_cnt), 32'h0100);
        go(6'd0, 6'b100000);
        rd_ch = 3'd7; #1; chk("R10 rd out of range", 32'(rd_cnt), 0);

        // R7 double buffering on PWM
        wr(2, 0, 16'h0002); wr(2, 1, 16'hFFF0); wr(2, 2, 16'hFFF8);
        go(6'b000100, 6'd0);
        ticks(0, 7);
        rd_ch = 3'd2; #1;
        chk("R7 pre cnt", 32'(rd_cnt), 32'hFFF7);
        wr(2, 1, 16'hFFF4); wr(2, 2, 16'hFFF6);
        chk("R7 old cmp kept", 32'(tmr_out[2]), 1);
        ticks(0, 9);
        chk("R7 new reload", 32'(rd_cnt), 32'hFFF4);
        ticks(0, 2);
        chk("R7 new cmp", 32'(tmr_out[2]), 0);
        go(6'd0, 6'b000100);

        // R8 capture
        wr(3, 0, 16'h0003); wr(3, 1, 16'h1230);
        mon_ch = 3; rd_ch = 3'd3;
        go(6'b001000, 6'd0);
        ticks(0, 5);
        @(negedge clk); irq_seen = 0;
        cap_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 rise cap", 32'(rd_cap), 32'h1235);
        chk("R8 rise irq", 32'(irq_seen), 1);
        ticks(0, 2);
        irq_seen = 0;
        cap_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 fall ignored", 32'(rd_cap), 32'h1235);
        chk("R8 fall no irq", 32'(irq_seen), 0);
        wr(3, 0, 16'h0023);
        cap_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 rise ignored", 32'(rd_cap), 32'h1235);
        cap_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 fall cap", 32'(rd_cap), 32'h1237);
        go(6'd0, 6'b001000);

        // R9 external clock
        wr(0, 0, 16'h001C); wr(0, 1, 16'h0000);
        wr(2, 0, 16'h001C); wr(2, 1, 16'h0042);
        go(6'b000101, 6'd0);
        @(negedge clk); pre_ce = 7'h7F;
        for (int p = 0; p < 3; p++) begin
            ext_clk = 2'b11; repeat (2) @(negedge clk);
            ext_clk = 2'b00; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        pre_ce = '0;
        rd_ch = 3'd0; #1; chk("R9 ext count", 32'(rd_cnt), 3);
        rd_ch = 3'd2; #1; chk("R9 no ext pin", 32'(rd_cnt), 32'h0042);
        go(6'd0, 6'b111111);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule